// File: doc/BRIEF.md
# Frequency Lock Supervisor for a Clock Recovery Loop

This block judges whether a clock recovered from a serial data stream runs at the same frequency as a local reference. It also decides what the recovery loop should follow. It counts rising edges of the recovered clock, after that clock has been divided down to the reference rate, over a fixed window of reference cycles. At the end of each window it compares the count with the window length. Two separate limits give the decision hysteresis. A locked loop is dropped only when the error exceeds the wide limit. A searching loop is declared locked only when the error is within the narrow limit.

When the loop is not locked, the select output holds it on the reference clock, so the output frequency stays correct. After a few reference windows the block releases the loop to the data for a bounded polling attempt. If the narrow test passes during that attempt, the loop is declared locked. If it does not pass, the loop returns to the reference.

Two override inputs act in the same cycle. The first is an active-low signal-detect input; when signal is lost, the block also forces the serial data seen by the loop to zero. The second is an active-low force-to-reference input. Either override pins the loop to the reference and keeps the lock flag low. The analog phase detector, filter and oscillator are not part of this block.

Top module: `freqLockMonitor`

## Requirements
- R1: While reset is held and after reset is released, lockDet is 0 and trackData is 0. Encoding: trackData 1 means follow the data, 0 means follow the reference.
- R2: While locked, the block leaves lock at the end of a window when the edge count differs from WIN_CYC by more than LOSE_THR. It then returns to reference mode.
- R3: A polling loop becomes locked at the end of a window whose count is within GAIN_THR of WIN_CYC. A locked loop whose error lies between GAIN_THR and LOSE_THR stays locked.
- R4: In reference mode, after HOLD_WIN complete evaluated windows, trackData goes to 1 for a polling attempt. If no window in POLL_WIN windows passes the narrow test, the block goes back to reference mode.
- R5: While sigDetN is 1, serDataOut is 0 in the same cycle, and both trackData and lockDet are 0. Otherwise serDataOut equals serDataIn.
- R6: While forceRefN is 0, trackData and lockDet are 0 in the same cycle. When the override is released, the block starts again in reference mode with the hold count cleared.
- R7: lockDet is 1 exactly while the loop is judged locked to data, and lockDet 1 implies trackData 1.
- R8: The first window after reset only records a baseline count and moves no state. A decision takes effect within two reference cycles after the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock; all decisions are made in this domain |
| recClk | input | 1 | Recovered clock divided to the reference rate |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sigDetN | input | 1 | Signal detect, active low (1 = signal lost) |
| forceRefN | input | 1 | Force loop onto reference, active low |
| serDataIn | input | 1 | Serial data toward the loop |
| serDataOut | output | 1 | Serial data gated to 0 while signal is lost |
| lockDet | output | 1 | 1 while locked to the incoming data |
| trackData | output | 1 | 1 = loop follows data, 0 = loop follows reference |

## Verification
The gating of serial data and both overrides act combinationally, so the bench checks them 1 ns after it changes an input. Lock decisions land two reference cycles after a window closes: one cycle to register the window result and one for the state register. The bench therefore samples only in the middle of a window, where every output is stable. A window-level model steps once per window and predicts each output. Recovered-clock frequencies are changed only while an override is active or while the model is locked. In these cases a window that mixes two frequencies still has a single predictable outcome.

// File: rtl/flmPkg.sv
package flmPkg;

  // per-window result handed from datapath to control
  typedef struct packed {
    logic done;     // a compared window just closed
    logic inGain;   // error within the narrow (acquire) limit
    logic outLose;  // error beyond the wide (drop) limit
  } winStatus_t;

  typedef enum logic [1:0] {
    ST_REF  = 2'd0,
    ST_POLL = 2'd1,
    ST_LOCK = 2'd2
  } lockState_t;

endpackage

// File: rtl/flmDatapath.sv
module flmDatapath
  import flmPkg::*;
#(
  parameter int WIN_CYC  = 32768,
  parameter int GAIN_THR = 10,
  parameter int LOSE_THR = 20
) (
  input  logic       refClk,
  input  logic       recClk,
  input  logic       rstN,
  output winStatus_t status
);

  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int CNT_W = WIN_W + 2;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] EXP_CNT  = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] GAIN_LIM = CNT_W'(GAIN_THR);
  localparam logic [CNT_W-1:0] LOSE_LIM = CNT_W'(LOSE_THR);

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b = g;
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // recovered-clock domain: free-running edge counter, Gray coded
  logic [CNT_W-1:0] recBin, recBinNext, recGray;
  assign recBinNext = recBin + 1'b1;

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      recBin  <= '0;
      recGray <= '0;
    end else begin
      recBin  <= recBinNext;
      recGray <= recBinNext ^ (recBinNext >> 1);
    end
  end

  // reference domain: two-flop capture of the Gray count
  logic [CNT_W-1:0] grayMeta, graySync, syncBin;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      grayMeta <= '0;
      graySync <= '0;
    end else begin
      grayMeta <= recGray;
      graySync <= grayMeta;
    end
  end

  assign syncBin = grayToBin(graySync);

  // measurement window
  logic [WIN_W-1:0] winCnt;
  logic             winEnd, baseValid;
  logic [CNT_W-1:0] baseCnt, delta, diffRaw, absDiff;

  assign winEnd  = (winCnt == WIN_LAST);
  assign delta   = syncBin - baseCnt;
  assign diffRaw = delta - EXP_CNT;
  assign absDiff = diffRaw[CNT_W-1] ? (CNT_W'(0) - diffRaw) : diffRaw;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else       winCnt <= winEnd ? '0 : winCnt + 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      status    <= '0;
      baseCnt   <= '0;
      baseValid <= 1'b0;
    end else begin
      status.done <= winEnd && baseValid;
      if (winEnd) begin
        baseCnt        <= syncBin;
        baseValid      <= 1'b1;
        status.inGain  <= (absDiff <= GAIN_LIM);
        status.outLose <= (absDiff > LOSE_LIM);
      end
    end
  end

  AST_CLASS_DISJOINT: assert property (@(posedge refClk) disable iff (!rstN)
    status.done |-> !(status.inGain && status.outLose)) else $error("window both near and far"); // R3

  AST_DONE_SINGLE: assert property (@(posedge refClk) disable iff (!rstN)
    status.done |=> !status.done) else $error("window strobe longer than one cycle"); // R8

endmodule

// File: rtl/flmControl.sv
module flmControl
  import flmPkg::*;
#(
  parameter int HOLD_WIN = 2,
  parameter int POLL_WIN = 8
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       sigDetN,
  input  logic       forceRefN,
  input  winStatus_t status,
  output logic       lockDet,
  output logic       trackData
);

  localparam int HW = $clog2(HOLD_WIN + 1);
  localparam int PW = $clog2(POLL_WIN + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_WIN - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_WIN - 1);

  lockState_t    stateQ, stateD;
  logic [HW-1:0] holdQ, holdD;
  logic [PW-1:0] pollQ, pollD;
  logic          forced;

  assign forced = sigDetN | ~forceRefN;

  always_comb begin
    stateD = stateQ;
    holdD  = holdQ;
    pollD  = pollQ;
    if (forced) begin
      stateD = ST_REF;
      holdD  = '0;
      pollD  = '0;
    end else if (status.done) begin
      unique case (stateQ)
        ST_REF: begin
          if (holdQ == HOLD_LAST) begin
            stateD = ST_POLL;
            holdD  = '0;
            pollD  = '0;
          end else begin
            holdD = holdQ + 1'b1;
          end
        end
        ST_POLL: begin
          if (status.inGain) begin
            stateD = ST_LOCK;
            pollD  = '0;
          end else if (pollQ == POLL_LAST) begin
            stateD = ST_REF;
            pollD  = '0;
            holdD  = '0;
          end else begin
            pollD = pollQ + 1'b1;
          end
        end
        ST_LOCK: begin
          if (status.outLose) begin
            stateD = ST_REF;
            holdD  = '0;
          end
        end
        default: begin
          stateD = ST_REF;
          holdD  = '0;
          pollD  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_REF;
      holdQ  <= '0;
      pollQ  <= '0;
    end else begin
      stateQ <= stateD;
      holdQ  <= holdD;
      pollQ  <= pollD;
    end
  end

  assign lockDet   = (stateQ == ST_LOCK) && !forced;
  assign trackData = (stateQ != ST_REF) && !forced;

  AST_FORCE_TO_REF: assert property (@(posedge refClk) disable iff (!rstN)
    forced |=> (stateQ == ST_REF)) else $error("override did not return to reference"); // R6

  AST_LOCK_ON_GAIN: assert property (@(posedge refClk) disable iff (!rstN)
    (stateQ == ST_LOCK && $past(stateQ) != ST_LOCK)
      |-> $past(status.done && status.inGain && stateQ == ST_POLL)) else $error("lock without narrow pass"); // R3

  AST_LOSE_ON_FAR: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(stateQ) == ST_LOCK && stateQ == ST_REF && !$past(forced))
      |-> $past(status.done && status.outLose)) else $error("lock dropped without wide fail"); // R2

  AST_NO_SKIP_POLL: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(stateQ) == ST_REF) |-> (stateQ != ST_LOCK)) else $error("locked straight from reference"); // R4

  AST_POLL_BOUNDED: assert property (@(posedge refClk) disable iff (!rstN)
    pollQ < PW'(POLL_WIN)) else $error("polling counter overran"); // R4

endmodule

// File: rtl/freqLockMonitor.sv
module freqLockMonitor
  import flmPkg::*;
#(
  parameter int WIN_CYC  = 32768,
  parameter int GAIN_THR = 10,
  parameter int LOSE_THR = 20,
  parameter int HOLD_WIN = 2,
  parameter int POLL_WIN = 8
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  input  logic sigDetN,
  input  logic forceRefN,
  input  logic serDataIn,
  output logic serDataOut,
  output logic lockDet,
  output logic trackData
);

  winStatus_t winStatus;

  assign serDataOut = serDataIn & ~sigDetN;

  flmDatapath #(
    .WIN_CYC (WIN_CYC),
    .GAIN_THR(GAIN_THR),
    .LOSE_THR(LOSE_THR)
  ) i_datapath (
    .refClk(refClk),
    .recClk(recClk),
    .rstN  (rstN),
    .status(winStatus)
  );

  flmControl #(
    .HOLD_WIN(HOLD_WIN),
    .POLL_WIN(POLL_WIN)
  ) i_control (
    .refClk   (refClk),
    .rstN     (rstN),
    .sigDetN  (sigDetN),
    .forceRefN(forceRefN),
    .status   (winStatus),
    .lockDet  (lockDet),
    .trackData(trackData)
  );

  AST_LOCK_IMPLIES_TRACK: assert property (@(posedge refClk) disable iff (!rstN)
    lockDet |-> trackData) else $error("lock flag while following reference"); // R7

endmodule

// File: tb/test_freqLockMonitor.sv
module test_freqLockMonitor;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  WIN  = 256;
  localparam int  GAIN = 4;
  localparam int  LOSE = 12;
  localparam int  HOLD = 2;
  localparam int  POLL = 8;
  localparam real PER_MATCH = 8.0;   // error 0 counts
  localparam real PER_MID   = 7.76;  // error about 8 counts
  localparam real PER_FAR   = 7.0;   // error about 37 counts

  logic refClk = 1'b0, recClk = 1'b0, rstN = 1'b0;
  logic sigDetN = 1'b0, forceRefN = 1'b1, serDataIn = 1'b0;
  logic serDataOut, lockDet, trackData;
  real  recPer = PER_MATCH;
  real  perOld = PER_MATCH;
  int   tests = 0, fails = 0, cycles = 0;
  int   mState = 0, mHold = 0, mPoll = 0, boundaries = 0;

  always #4 refClk = ~refClk;
  always #(recPer / 2.0) recClk = ~recClk;

  freqLockMonitor #(
    .WIN_CYC(WIN), .GAIN_THR(GAIN), .LOSE_THR(LOSE), .HOLD_WIN(HOLD), .POLL_WIN(POLL)
  ) i_freqLockMonitor (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .sigDetN(sigDetN),
    .forceRefN(forceRefN), .serDataIn(serDataIn), .serDataOut(serDataOut),
    .lockDet(lockDet), .trackData(trackData)
  );

  always @(posedge refClk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most 200000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic real pickPer(input int k);
    case (k)
      0:       return PER_MATCH;
      1:       return PER_MID;
      default: return PER_FAR;
    endcase
  endfunction

  function automatic real windowErr(input real pA, input real pB);
    real c;
    c = (WIN / 2) * 8.0 / pA + (WIN / 2) * 8.0 / pB - WIN;
    return (c < 0.0) ? -c : c;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    logic frc;
    frc = sigDetN | ~forceRefN;
    check(lockDet, (mState == 2) && !frc, {tag, " lockDet"});
    check(trackData, (mState != 0) && !frc, {tag, " trackData"});
  endtask

  // window-level reference model, stepped once per closed window
  task automatic modelBoundary();
    real  e;
    logic frc;
    boundaries++;
    frc = sigDetN | ~forceRefN;
    e = windowErr(perOld, recPer);
    perOld = recPer;
    if (boundaries < 2) return;  // R8 baseline window
    if (frc) begin
      mState = 0; mHold = 0; mPoll = 0;
    end else begin
      case (mState)
        0: if (mHold == HOLD - 1) begin mState = 1; mHold = 0; mPoll = 0; end
           else mHold++;
        1: if (e <= GAIN) begin mState = 2; mPoll = 0; end
           else if (mPoll == POLL - 1) begin mState = 0; mPoll = 0; mHold = 0; end
           else mPoll++;
        default: if (e > LOSE) begin mState = 0; mHold = 0; end
      endcase
    end
  endtask

  task automatic advance(input string tag);
    repeat (WIN) @(posedge refClk);
    @(negedge refClk);
    modelBoundary();
    checkOutputs(tag);
  endtask

  task automatic setInputs(input logic sd, input logic fr, input real p);
    sigDetN   = sd;
    forceRefN = fr;
    recPer    = p;
    serDataIn = 1'($urandom % 2);
    #1;
    check(serDataOut, serDataIn & ~sigDetN, "R5 serDataOut gating");
    if (sigDetN) checkOutputs("R5 signal lost");
    else if (!forceRefN) checkOutputs("R6 forced to reference");
    else checkOutputs("R7 override idle");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    check(lockDet, 1'b0, "R1 lockDet in reset");
    check(trackData, 1'b0, "R1 trackData in reset");
    rstN = 1'b1;
    repeat (WIN / 2) @(posedge refClk);
    @(negedge refClk);
    check(lockDet, 1'b0, "R1 lockDet after reset");
    check(trackData, 1'b0, "R1 trackData after reset");

    advance("R8 baseline window");
    advance("R4 hold window");
    advance("R4 polling starts");
    advance("R3 narrow pass locks");
    advance("R7 steady lock");

    setInputs(1'b0, 1'b1, PER_MID);
    advance("R3 hysteresis mixed window");
    advance("R3 hysteresis mid offset");
    setInputs(1'b0, 1'b1, PER_FAR);
    advance("R2 wide fail drops lock");
    for (int i = 0; i < 12; i++) advance("R4 poll timeout far");

    setInputs(1'b0, 1'b0, PER_MATCH);
    advance("R6 held on reference");
    advance("R6 held on reference");
    setInputs(1'b0, 1'b1, PER_MATCH);
    for (int i = 0; i < 4; i++) advance("R6 restart after release");

    setInputs(1'b1, 1'b1, PER_MATCH);
    advance("R5 signal lost");
    setInputs(1'b0, 1'b1, PER_MATCH);
    for (int i = 0; i < 4; i++) advance("R5 signal restored");

    for (int i = 0; i < 120; i++) begin
      int   r;
      logic sd, fr, wasForced, nowForced;
      real  p;
      r  = int'($urandom % 8);
      sd = sigDetN;
      fr = forceRefN;
      p  = recPer;
      wasForced = sigDetN | ~forceRefN;
      if (r == 0) fr = ~fr;
      else if (r == 1) sd = ~sd;
      nowForced = sd | ~fr;
      if (nowForced && r < 2) p = pickPer(int'($urandom % 3));
      else if (!wasForced && !nowForced && mState == 2 && (r == 2 || r == 3))
        p = pickPer(int'($urandom % 3));
      setInputs(sd, fr, p);
      advance("R7 random window");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule